// File: doc/BRIEF.md
# Programmable Watchdog Timer with Steerable Expiry

This block is a watchdog timer driven by an external time-base tick. Software programs one 8-bit control byte. The byte holds a five-bit multiplier, a two-bit resolution code and a steering bit. The timeout equals the multiplier times a resolution unit, and each resolution unit is a power-of-four number of ticks. Writing the control byte restarts the countdown. When software stops writing and the countdown reaches its end, the block raises one of two active-low outputs.

The steering bit picks the output. It can latch a watchdog flag that holds the interrupt line low until the flags register is read. It can instead drive the reset output low for a fixed number of clock cycles. A multiplier of zero turns the watchdog off, and the control byte clears to zero at reset, so the block starts disabled. After each expiry the countdown reloads by itself and runs again with the same period.

Top module: `wdg_timer`

## Requirements
- R1: After reset, `irq_n` and `rst_out_n` are both 1, and no timeout occurs for any number of ticks until the control byte is written with a nonzero multiplier.
- R2: Writing the control byte with multiplier 0 disables the watchdog, and neither output goes low for any number of ticks.
- R3: The control byte is `wr_data[7]` = steer, `wr_data[6:2]` = multiplier M and `wr_data[1:0]` = resolution code R. After the write, the timeout takes effect on exactly the (M * 4^R)-th tick. Outputs stay high on all earlier ticks.
- R4: A write during a countdown restarts it, and the next timeout needs the full M * 4^R ticks counted from that write.
- R5: With steer = 0, a timeout sets the watchdog flag. `irq_n` is low from the clock after the expiring tick and stays low until a flags read. `rst_out_n` stays 1.
- R6: A `flag_rd` pulse clears the flag, and `irq_n` returns to 1 on the next clock. If a timeout falls in the same cycle as the read, the flag stays set.
- R7: With steer = 1, a timeout drives `rst_out_n` low for exactly RST_CYCLES clocks (8 by default). The flag is not set, so `irq_n` stays 1.
- R8: After a timeout the countdown reloads itself. With no further write, the next timeout follows after another M * 4^R ticks.
- R9: A tick in the same cycle as a write is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base pulse |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte: steer, multiplier, resolution |
| flag_rd | input | 1 | Flags-register read strobe; clears the watchdog flag |
| irq_n | output | 1 | Active-low interrupt, low while the watchdog flag is set |
| rst_out_n | output | 1 | Active-low reset pulse output |

## Verification
Three conditions are hard to reach from the ports. The first is a timeout that lands in the same cycle as a flags read. The second is a write that coincides with a tick. The third is the second timeout of a free-running countdown. The stimulus sets each one up deterministically. It uses a multiplier of one at the finest resolution, so every tick expires and can be paired with a read. It raises the write strobe and the tick together and then counts the remaining ticks one by one. Long resolutions are reached with small multipliers, so the 4^R scaling is checked up to 128 ticks without long runs.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int CFG_W  = 1 + MULT_W + RES_W;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdg_cfg_t;

  // ticks per resolution unit: 2^(step_log2 * res)
  function automatic int unsigned unit_ticks(input logic [RES_W-1:0] res,
                                             input int step_log2);
    return 32'd1 << (step_log2 * int'(res));
  endfunction
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale
  import wdg_pkg::*;
#(
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             restart,
  input  logic [RES_W-1:0] res,
  output logic             unit_end
);
  localparam int PS_W = STEP_LOG2 * ((1 << RES_W) - 1) + 1;

  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] last;

  assign last     = PS_W'(unit_ticks(res, STEP_LOG2) - 1);
  assign unit_end = tick && en && !restart && (pcnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (restart || !en) begin
      pcnt <= '0;
    end else if (tick) begin
      pcnt <= unit_end ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_count.sv
module wdg_count
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MULT_W-1:0] load_val,
  input  logic [MULT_W-1:0] reload_val,
  input  logic              unit_end,
  output logic              expire
);
  logic [MULT_W-1:0] cnt;

  assign expire = unit_end && (cnt == MULT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (unit_end) begin
      cnt <= expire ? reload_val : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_out.sv
module wdg_out #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  input  logic flag_rd,
  output logic irq_n,
  output logic rst_out_n
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic            flag;
  logic [RC_W-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (expire && !steer) begin
      flag <= 1'b1;
    end else if (flag_rd) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= '0;
    end else if (expire && steer) begin
      rcnt <= RC_W'(RST_CYCLES);
    end else if (rcnt != '0) begin
      rcnt <= rcnt - 1'b1;
    end
  end

  assign irq_n     = !flag;
  assign rst_out_n = (rcnt == '0);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int STEP_LOG2  = 2,
  parameter int RST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             flag_rd,
  output logic             irq_n,
  output logic             rst_out_n
);
  wdg_cfg_t          cfg_q;
  wdg_cfg_t          cfg_in;
  logic              enabled;
  logic              unit_end;
  logic              expire;
  logic              cfg_steer;
  logic [MULT_W-1:0] cfg_mult;

  assign cfg_in    = wdg_cfg_t'(wr_data);
  assign enabled   = (cfg_q.mult != '0);
  assign cfg_steer = cfg_q.steer;
  assign cfg_mult  = cfg_q.mult;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_in;
    end
  end

  wdg_prescale #(.STEP_LOG2(STEP_LOG2)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en       (enabled),
    .restart  (wr_en),
    .res      (cfg_q.res),
    .unit_end (unit_end)
  );

  wdg_count u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wr_en),
    .load_val   (cfg_in.mult),
    .reload_val (cfg_q.mult),
    .unit_end   (unit_end),
    .expire     (expire)
  );

  wdg_out #(.RST_CYCLES(RST_CYCLES)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .steer     (cfg_steer),
    .flag_rd   (flag_rd),
    .irq_n     (irq_n),
    .rst_out_n (rst_out_n)
  );
endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk #(
  parameter int RST_CYCLES = 8,
  parameter int MW         = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          expire,
  input logic          cfg_steer,
  input logic [MW-1:0] cfg_mult,
  input logic          flag_rd,
  input logic          irq_n,
  input logic          rst_out_n
);
  localparam int SW = $clog2(RST_CYCLES + 2) + 1;

  logic [SW-1:0] since_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_exp <= SW'(RST_CYCLES + 1);
    end else if (expire && cfg_steer) begin
      since_exp <= '0;
    end else if (since_exp <= SW'(RST_CYCLES)) begin
      since_exp <= since_exp + 1'b1;
    end
  end

  assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mult == '0) |-> !expire);

  assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cfg_steer) |=> !irq_n);

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !flag_rd) |=> !irq_n);

  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !expire) |=> irq_n);

  assert_rst_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cfg_steer) |=> !rst_out_n);

  assert_rst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> (since_exp == SW'(RST_CYCLES)));

  assert_no_irq_on_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cfg_steer && !flag_rd) |=> (irq_n == $past(irq_n)));
endmodule

bind wdg_timer wdg_timer_chk #(.RST_CYCLES(RST_CYCLES), .MW(wdg_pkg::MULT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .expire    (expire),
  .cfg_steer (cfg_steer),
  .cfg_mult  (cfg_mult),
  .flag_rd   (flag_rd),
  .irq_n     (irq_n),
  .rst_out_n (rst_out_n)
);

// File: tb/wdg_timer_tb.sv
module wdg_timer_tb;
  localparam int RST_CYCLES = 8;
  localparam int NV = 6;
  // control byte {steer, mult[4:0], res[1:0]} and expected tick count
  localparam logic [7:0] VCFG [NV] = '{
    {1'b0, 5'd1,  2'd0},
    {1'b0, 5'd5,  2'd0},
    {1'b0, 5'd3,  2'd1},
    {1'b1, 5'd2,  2'd2},
    {1'b0, 5'd2,  2'd3},
    {1'b1, 5'd31, 2'd0}
  };
  localparam int VTICKS [NV] = '{1, 5, 12, 32, 128, 31};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       flag_rd = 1'b0;
  logic       irq_n;
  logic       rst_out_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdg_timer #(.STEP_LOG2(2), .RST_CYCLES(RST_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .flag_rd(flag_rd), .irq_n(irq_n), .rst_out_n(rst_out_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input bit with_tick);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic do_tick(input bit with_rd);
    @(negedge clk);
    tick = 1'b1; flag_rd = with_rd;
    @(negedge clk);
    tick = 1'b0; flag_rd = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk);
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  // expected tick count from the requirement, not from the table
  function automatic int exp_ticks(input logic [7:0] d);
    return int'(d[6:2]) * (4 ** int'(d[1:0]));
  endfunction

  function automatic int pulse_len_dummy();
    return RST_CYCLES;
  endfunction

  task automatic measure_pulse(output int n);
    n = 0;
    while (!rst_out_n && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int quiet;
    int plen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);
    chk(rst_out_n == 1'b1, "R1 rst_out_n after reset", rst_out_n, 1);
    quiet = 1;
    for (int i = 0; i < 40; i++) begin
      do_tick(1'b0);
      if (!irq_n || !rst_out_n) quiet = 0;
    end
    chk(quiet == 1, "R1 disabled after reset", quiet, 1);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      int n;
      n = exp_ticks(VCFG[v]);
      chk(n == VTICKS[v], "R3 table consistency", VTICKS[v], n);
      do_write(VCFG[v], 1'b0);
      quiet = 1;
      for (int t = 1; t < n; t++) begin
        do_tick(1'b0);
        if (!irq_n || !rst_out_n) quiet = 0;
      end
      chk(quiet == 1, "R3 no early timeout", quiet, 1);
      do_tick(1'b0);
      if (VCFG[v][7] == 1'b0) begin
        chk(irq_n == 1'b0, "R5 irq_n low on timeout", irq_n, 0);
        chk(rst_out_n == 1'b1, "R5 rst_out_n stays high", rst_out_n, 1);
        repeat (5) @(negedge clk);
        chk(irq_n == 1'b0, "R5 irq_n held", irq_n, 0);
        do_read();
        chk(irq_n == 1'b1, "R6 read clears flag", irq_n, 1);
      end else begin
        chk(irq_n == 1'b1, "R7 irq_n stays high", irq_n, 1);
        measure_pulse(plen);
        chk(plen == pulse_len_dummy(), "R7 reset pulse length", plen, RST_CYCLES);
        chk(irq_n == 1'b1, "R7 no flag after pulse", irq_n, 1);
      end
    end

    // R2: multiplier zero disables
    do_write({1'b0, 5'd0, 2'd0}, 1'b0);
    quiet = 1;
    for (int i = 0; i < 60; i++) begin
      do_tick(1'b0);
      if (!irq_n || !rst_out_n) quiet = 0;
    end
    chk(quiet == 1, "R2 mult zero disabled", quiet, 1);

    // R4: rewrite restarts
    do_write({1'b0, 5'd3, 2'd0}, 1'b0);
    do_tick(1'b0); do_tick(1'b0);
    do_write({1'b0, 5'd3, 2'd0}, 1'b0);
    do_tick(1'b0); do_tick(1'b0);
    chk(irq_n == 1'b1, "R4 restart delays timeout", irq_n, 1);
    do_tick(1'b0);
    chk(irq_n == 1'b0, "R4 timeout after full period", irq_n, 0);
    do_read();

    // R9: tick coinciding with write is not counted
    do_write({1'b0, 5'd2, 2'd0}, 1'b1);
    do_tick(1'b0);
    chk(irq_n == 1'b1, "R9 tick with write ignored", irq_n, 1);
    do_tick(1'b0);
    chk(irq_n == 1'b0, "R9 timeout on second tick", irq_n, 0);
    do_read();

    // R8: free-running reload
    do_write({1'b0, 5'd2, 2'd1}, 1'b0);
    for (int t = 0; t < 8; t++) do_tick(1'b0);
    chk(irq_n == 1'b0, "R8 first timeout", irq_n, 0);
    do_read();
    chk(irq_n == 1'b1, "R8 flag cleared", irq_n, 1);
    quiet = 1;
    for (int t = 1; t < 8; t++) begin
      do_tick(1'b0);
      if (!irq_n) quiet = 0;
    end
    chk(quiet == 1, "R8 no early second timeout", quiet, 1);
    do_tick(1'b0);
    chk(irq_n == 1'b0, "R8 second timeout", irq_n, 0);
    do_read();

    // R6: expiry in same cycle as read keeps flag
    do_write({1'b0, 5'd1, 2'd0}, 1'b0);
    do_tick(1'b0);
    chk(irq_n == 1'b0, "R6 setup timeout", irq_n, 0);
    do_tick(1'b1);
    chk(irq_n == 1'b0, "R6 expiry beats read", irq_n, 0);
    do_read();
    chk(irq_n == 1'b1, "R6 plain read clears", irq_n, 1);
    do_write({1'b0, 5'd0, 2'd0}, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule